// File: doc/BRIEF.md
# Linear Array Readout Sequencer

This block is the digital control of a linear image sensor with a row of light-sensitive elements. A one-cycle start pulse, sampled on a rising clock edge while the block is idle, injects a single token into a shift chain. The token walks one stage per clock, and each stage selects one element for the analog output path. After the last element the chain empties itself, and the output stage is released so that several sensors can share an analog line.

The token also leaves the block on a serial output while the last element is presented. That output can drive the start input of a second sensor on the same clock, so that sensors can be chained end to end with no gap. Two clock-phase controls are produced for the analog front end: a strobe that clears the sense node in every clock period, and a track/hold control that tracks only while the clock is high during a readout. For checking, the selected position is also given as a binary index with a valid flag.

Top module: `readout_seq_top`

## Requirements
- R1: When start_i is high on a rising edge while no readout is active, sel_o[0] is high and oe_o is high after that edge.
- R2: During a readout, every later rising edge moves the single set bit of sel_o up by one position. sel_o never has more than one bit set.
- R3: so_o is high exactly while sel_o[N-1] is high, which is the cycle after the N-th edge counting the starting edge as the first.
- R4: On edge N+1 of a readout, sel_o becomes all zero and oe_o falls.
- R5: start_i has no effect while a readout is active, including on edge N+1. A start on edge N+2 begins a new readout.
- R6: oe_o is high for exactly N consecutive cycles per readout, and it is high exactly when some bit of sel_o is high.
- R7: node_clr_o is high during the low half of every clock period and low during the high half, whether or not a readout is active.
- R8: sample_o follows the clock level while oe_o is high and is low otherwise.
- R9: idx_o gives the binary position of the set sel_o bit, with 0 for the first element, and idx_vld_o equals oe_o. idx_o is 0 while idle.
- R10: An active-high synchronous reset_i clears sel_o, oe_o, so_o and idx_o on the next rising edge, also in the middle of a readout.
- R11: A second sequencer whose start input is driven by so_o presents its first element on the same edge on which the first sequencer ends its readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sensor clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse, sampled on the rising edge |
| sel_o | output | N | One-hot element select |
| oe_o | output | 1 | Output stage enable during readout |
| node_clr_o | output | 1 | Sense-node clear strobe (clock low half) |
| sample_o | output | 1 | Track/hold control (high = track) |
| so_o | output | 1 | Serial token out for chaining |
| idx_o | output | IW | Binary index of the selected element |
| idx_vld_o | output | 1 | idx_o is meaningful |

## Verification
The bench builds the main instance with N = 64, so that the full readout length, the 6-bit index wrap and the serial output on the last stage are all covered. A second instance with N = 8 is driven from so_o. It shows that the chain hands over on the edge that ends the first readout, and that a short chain empties and rearms correctly. A start held high for many cycles makes back-to-back readouts that restart on edge 66. Single pulses placed on edge 65, in the middle of a readout and under reset cover the cases where the start must be ignored.

// File: rtl/readout_seq_pkg.sv
package readout_seq_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_READ = 1'b1
  } seq_state_e;

  // Index width for a chain of n stages (at least one bit).
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // A start is taken only when no token is in flight.
  function automatic logic take_start(input logic start, input seq_state_e st);
    return start && (st == SEQ_IDLE);
  endfunction

  // Next binary position: restart at zero, step during readout, zero at end or idle.
  function automatic logic [31:0] step_index(input logic [31:0] cur, input logic restart,
                                              input logic active, input logic last);
    if (restart)           return 32'd0;
    if (active && !last)   return cur + 32'd1;
    return 32'd0;
  endfunction

endpackage

// File: rtl/token_chain.sv
module token_chain #(
  parameter int unsigned N = 64
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         inject_i,
  output logic [N-1:0] stage_o,
  output logic         tail_o
);
  logic [N-1:0] stage_q;
  logic         tail_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) stage_q[0] <= 1'b0;
    else       stage_q[0] <= inject_i;
  end

  for (genvar k = 1; k < N; k++) begin : g_stage
    always_ff @(posedge clk_i) begin
      if (rst_i) stage_q[k] <= 1'b0;
      else       stage_q[k] <= stage_q[k-1];
    end
  end

  // Separate flop that follows the token into the final stage.
  always_ff @(posedge clk_i) begin
    if (rst_i) tail_q <= 1'b0;
    else       tail_q <= stage_q[N-2];
  end

  assign stage_o = stage_q;
  assign tail_o  = tail_q;
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import readout_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic start_i,
  input  logic last_i,
  output logic inject_o,
  output logic active_o
);
  seq_state_e state_q;
  logic       take;

  assign take = take_start(start_i, state_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= SEQ_IDLE;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (take)   state_q <= SEQ_READ;
        SEQ_READ: if (last_i) state_q <= SEQ_IDLE;
        default:              state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign inject_o = take;
  assign active_o = (state_q == SEQ_READ);
endmodule

// File: rtl/index_counter.sv
module index_counter
  import readout_seq_pkg::*;
#(
  parameter int unsigned IW = 6
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          restart_i,
  input  logic          active_i,
  input  logic          last_i,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] idx_q;
  logic [31:0]   nxt;

  assign nxt = step_index(32'(idx_q), restart_i, active_i, last_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) idx_q <= '0;
    else       idx_q <= nxt[IW-1:0];
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/phase_gen.sv
module phase_gen (
  input  logic clk_i,
  input  logic active_i,
  output logic node_clr_o,
  output logic sample_o
);
  // Two non-overlapping phases: clear on the low half, track on the high half.
  assign node_clr_o = ~clk_i;
  assign sample_o   = clk_i & active_i;
endmodule

// File: rtl/readout_seq_top.sv
module readout_seq_top
  import readout_seq_pkg::*;
#(
  parameter int unsigned N  = 64,
  parameter int unsigned IW = idx_bits(N)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          start_i,
  output logic [N-1:0]  sel_o,
  output logic          oe_o,
  output logic          node_clr_o,
  output logic          sample_o,
  output logic          so_o,
  output logic [IW-1:0] idx_o,
  output logic          idx_vld_o
);
  logic inject;
  logic active;
  logic last_stage;

  token_chain #(.N(N)) u_chain (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .inject_i (inject),
    .stage_o  (sel_o),
    .tail_o   (so_o)
  );

  assign last_stage = sel_o[N-1];

  seq_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .start_i  (start_i),
    .last_i   (last_stage),
    .inject_o (inject),
    .active_o (active)
  );

  index_counter #(.IW(IW)) u_idx (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .restart_i (inject),
    .active_i  (active),
    .last_i    (last_stage),
    .idx_o     (idx_o)
  );

  phase_gen u_phase (
    .clk_i      (clk_i),
    .active_i   (active),
    .node_clr_o (node_clr_o),
    .sample_o   (sample_o)
  );

  assign oe_o      = active;
  assign idx_vld_o = active;
endmodule

// File: rtl/readout_seq_chk.sv
module readout_seq_chk #(
  parameter int unsigned N  = 64,
  parameter int unsigned IW = 6
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          start_i,
  input logic [N-1:0]  sel,
  input logic          oe,
  input logic          so,
  input logic [IW-1:0] idx
);
  assert_start_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && (sel == '0)) |=> sel[0]);

  assert_onehot_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(sel));

  assert_so_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    so == sel[N-1]);

  assert_end_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    sel[N-1] |=> (!oe && (sel == '0)));

  assert_ignore_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && (sel != '0)) |=> !sel[0]);

  assert_oe_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    oe == (sel != '0));

  assert_idx_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    oe |-> sel[idx]);

  assert_reset_R10: assert property (@(posedge clk_i)
    rst_i |=> ((sel == '0) && !oe && !so && (idx == '0)));
endmodule

bind readout_seq_top readout_seq_chk #(.N(N), .IW(IW)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .start_i (start_i),
  .sel     (sel_o),
  .oe      (oe_o),
  .so      (so_o),
  .idx     (idx_o)
);

// File: tb/tb_readout_seq_top.sv
module tb_readout_seq_top;
  localparam int N1 = 64;
  localparam int N2 = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;

  logic [N1-1:0] sel;
  logic          oe, nclr, smp, so, vld;
  logic [5:0]    idx;
  logic [N2-1:0] sel2;
  logic          oe2, nclr2, smp2, so2, vld2;
  logic [2:0]    idx2;

  always #5 clk = ~clk;

  readout_seq_top #(.N(N1)) dut (
    .clk_i(clk), .rst_i(rst), .start_i(start), .sel_o(sel), .oe_o(oe),
    .node_clr_o(nclr), .sample_o(smp), .so_o(so), .idx_o(idx), .idx_vld_o(vld));

  readout_seq_top #(.N(N2)) dut_nxt (
    .clk_i(clk), .rst_i(rst), .start_i(so), .sel_o(sel2), .oe_o(oe2),
    .node_clr_o(nclr2), .sample_o(smp2), .so_o(so2), .idx_o(idx2), .idx_vld_o(vld2));

  typedef struct {
    int    p1;
    int    p2;
    string tag;
  } exp_t;

  exp_t q[$];
  int   pos1 = 0, pos2 = 0;
  int   nvec = 0, nfail = 0;
  bit   done = 0;
  string tag = "R10";

  function automatic int advance(int p, logic s, int n, logic r);
    if (r)      return 0;
    if (p == 0) return s ? 1 : 0;
    if (p == n) return 0;
    return p + 1;
  endfunction

  task automatic step(input logic s, input logic r);
    exp_t e;
    int   n1, n2;
    start = s;
    rst   = r;
    n1 = advance(pos1, s, N1, r);
    n2 = advance(pos2, (pos1 == N1), N2, r);
    pos1 = n1;
    pos2 = n2;
    e.p1 = n1; e.p2 = n2; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic chk(input string name, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h at %0t", name, act, exp, $time);
    end
  endtask

  // Monitor: high half of the clock, then low half.
  initial begin
    exp_t e;
    logic [63:0] es;
    forever begin
      @(posedge clk);
      #3;
      if (q.size() > 0) begin
        e  = q.pop_front();
        es = (e.p1 != 0) ? (64'd1 << (e.p1 - 1)) : 64'd0;
        chk({"sel ", e.tag, " R2"}, sel, es);
        chk("oe R6", 64'(oe), 64'(e.p1 != 0));
        chk("idx R9", 64'(idx), (e.p1 != 0) ? 64'(e.p1 - 1) : 64'd0);
        chk("vld R9", 64'(vld), 64'(e.p1 != 0));
        chk("so R3", 64'(so), 64'(e.p1 == N1));
        chk("nxt oe R11", 64'(oe2), 64'(e.p2 != 0));
        chk("nxt idx R11", 64'(idx2), (e.p2 != 0) ? 64'(e.p2 - 1) : 64'd0);
        chk("sample high R8", 64'(smp), 64'(e.p1 != 0));
        chk("clr high R7", 64'(nclr), 64'd0);
        #4;
        chk("sample low R8", 64'(smp), 64'd0);
        chk("clr low R7", 64'(nclr), 64'd1);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    // R10: reset state
    tag = "R10";
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    // R1 R4: single readout, then idle
    tag = "R1 R4";
    step(1'b1, 1'b0);
    for (int i = 0; i < 70; i++) step(1'b0, 1'b0);
    // R5: pulse on edge 65 is ignored
    tag = "R5 edge65";
    step(1'b1, 1'b0);
    for (int i = 0; i < 63; i++) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0);
    // R5: restart accepted on edge 66
    tag = "R5 edge66";
    step(1'b1, 1'b0);
    for (int i = 0; i < 64; i++) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    for (int i = 0; i < 70; i++) step(1'b0, 1'b0);
    // R5: pulses during readout are ignored
    tag = "R5 mid";
    step(1'b1, 1'b0);
    for (int i = 0; i < 70; i++) step((i % 10) == 4, 1'b0);
    // R5 R6: start held high gives back-to-back readouts
    tag = "R5 held";
    for (int i = 0; i < 140; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 70; i++) step(1'b0, 1'b0);
    // R10: reset in the middle of a readout
    tag = "R10 mid";
    step(1'b1, 1'b0);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0);
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    @(negedge clk);
    finish_run();
  end
endmodule